// File: doc/BRIEF.md
# Embedded Operations Message Qualifier

This block sits behind the framer that pulls embedded operations channel (eoc) words out of a line-side superframe stream. Each received word arrives with a one-cycle valid strobe. The block qualifies the word against a persistence rule chosen by a 2-bit mode input. A qualified word is copied into a held receive register, and an interrupt flag is raised toward the system, which clears it with an acknowledge pulse.

Four qualification modes exist. Mode 0 is a periodic pass-through: on every half-superframe tick, the most recently received word is copied out and the flag is raised, whatever the content. Mode 1 accepts any word that differs from the held one. Modes 2 and 3 accept a differing word only after it has arrived two or three times back to back with identical content. A word that breaks a run of identical receipts becomes the new candidate, and its run starts over at one. Reset clears the candidate, the run count and the held register. The first word after reset therefore always counts as new, even when it is all zeros.

Top module: `eoc_validate_filter`

## Requirements
- R1: While reset is applied, and after it is released, `rx_msg` reads 0 and `irq` reads 0.
- R2: With mode = 0, each cycle with `half_sf_tick` high loads `rx_msg` at the next clock edge and sets `irq`, regardless of content. The loaded value is the `msg_data` of that same cycle if `msg_vld` is high, or else the most recently received word.
- R3: With mode = 0, a received word without a tick changes neither `rx_msg` nor `irq`.
- R4: With mode = 1, a word that differs from `rx_msg` is loaded into `rx_msg` at the next clock edge, and `irq` is set.
- R5: In modes 1 to 3, a received word equal to the held `rx_msg` neither changes `rx_msg` nor sets `irq`.
- R6: With mode = 2, a new word is loaded, and `irq` is set, on the second identical receipt in a row, and not on the first.
- R7: With mode = 3, a new word is loaded, and `irq` is set, on the third identical receipt in a row, and not earlier.
- R8: A received word that differs from the word under confirmation restarts the run at one, with that word as the new candidate.
- R9: `irq` stays high until a cycle with `irq_ack` high and no load, and reads low after that edge. A load in the same cycle as `irq_ack` keeps `irq` high and overwrites `rx_msg`.
- R10: In modes 1 to 3, `half_sf_tick` has no effect on `rx_msg` or `irq`.
- R11: The first word received after reset is treated as new, even when its value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_vld | input | 1 | One-cycle strobe: an eoc word is present on msg_data |
| msg_data | input | MSG_W (8) | Received eoc word |
| half_sf_tick | input | 1 | One-cycle pulse every half superframe |
| mode | input | 2 | Qualification mode: 0 periodic, 1 on change, 2 two in a row, 3 three in a row |
| irq_ack | input | 1 | Clears the interrupt flag |
| rx_msg | output | MSG_W (8) | Held receive register with the last accepted word |
| irq | output | 1 | Interrupt flag: a word was accepted |

## Verification
The checker watches the following on every cycle, from the ports plus the held-valid bit:
- a flag that holds until it is acknowledged and drops after a quiet acknowledge;
- a periodic tick that always raises the flag in mode 0;
- a register that stays frozen without a strobe or tick, and frozen on repeats of the held word;
- an immediate load of every differing word in mode 1.

The run-length rules of modes 2 and 3 depend on the history of several receipts, so only the bench's scenarios show them. This covers the restart of a run when a different word breaks in, the sticky first word after reset, and the interaction of mode changes with a run in progress. The bench tests these with directed sequences and against a reference model under random traffic.

// File: rtl/eoc_filter_pkg.sv
package eoc_filter_pkg;

  typedef enum logic [1:0] {
    EOC_PASS  = 2'd0,
    EOC_NEW   = 2'd1,
    EOC_CONF1 = 2'd2,
    EOC_CONF2 = 2'd3
  } eoc_mode_e;

  localparam int CNT_W = 2;
  typedef logic [CNT_W-1:0] match_cnt_t;
  localparam match_cnt_t CNT_ONE = match_cnt_t'(1);
  localparam match_cnt_t CNT_MAX = '1;

  // identical receipts needed before a word is accepted
  function automatic match_cnt_t need_count(eoc_mode_e m);
    return match_cnt_t'(m);
  endfunction

endpackage

// File: rtl/eoc_rst_sync.sv
module eoc_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/eoc_persist_track.sv
module eoc_persist_track
  import eoc_filter_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             msg_vld,
  input  logic [MSG_W-1:0] msg_data,
  output logic [MSG_W-1:0] cand_nxt,
  output match_cnt_t       cnt_nxt
);

  logic [MSG_W-1:0] cand_q;
  match_cnt_t       cnt_q;
  logic             same_word;

  always_comb begin
    same_word = (cnt_q != '0) && (msg_data == cand_q);
    cand_nxt  = cand_q;
    cnt_nxt   = cnt_q;
    if (msg_vld) begin
      if (same_word) begin
        if (cnt_q != CNT_MAX) begin
          cnt_nxt = cnt_q + CNT_ONE;
        end
      end else begin
        cand_nxt = msg_data;
        cnt_nxt  = CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cand_q <= '0;
      cnt_q  <= '0;
    end else if (msg_vld) begin
      cand_q <= cand_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

endmodule

// File: rtl/eoc_accept_reg.sv
module eoc_accept_reg
  import eoc_filter_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic             clk,
  input  logic             rst_q,
  input  eoc_mode_e        mode,
  input  logic             half_sf_tick,
  input  logic             msg_vld,
  input  logic [MSG_W-1:0] cand_nxt,
  input  match_cnt_t       cnt_nxt,
  input  logic             irq_ack,
  output logic [MSG_W-1:0] rx_msg,
  output logic             irq,
  output logic             held_vld
);

  logic [MSG_W-1:0] rx_q, rx_d;
  logic             held_q, held_d;
  logic             irq_q, irq_d;
  logic             is_new;
  logic             load;

  always_comb begin
    is_new = !held_q || (cand_nxt != rx_q);
    if (mode == EOC_PASS) begin
      load = half_sf_tick;
    end else begin
      load = msg_vld && (cnt_nxt >= need_count(mode)) && is_new;
    end
    rx_d   = load ? cand_nxt : rx_q;
    held_d = held_q | load;
    irq_d  = load | (irq_q & ~irq_ack);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rx_q   <= '0;
      held_q <= 1'b0;
    end else if (load) begin
      rx_q   <= rx_d;
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign rx_msg   = rx_q;
  assign irq      = irq_q;
  assign held_vld = held_q;

endmodule

// File: rtl/eoc_validate_filter.sv
module eoc_validate_filter
  import eoc_filter_pkg::*;
#(
  parameter int MSG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_vld,
  input  logic [MSG_W-1:0] msg_data,
  input  logic             half_sf_tick,
  input  logic [1:0]       mode,
  input  logic             irq_ack,
  output logic [MSG_W-1:0] rx_msg,
  output logic             irq
);

  logic             rst_q;
  logic [MSG_W-1:0] cand_nxt;
  match_cnt_t       cnt_nxt;
  logic             held_vld;
  eoc_mode_e        mode_e;

  assign mode_e = eoc_mode_e'(mode);

  eoc_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  eoc_persist_track #(.MSG_W(MSG_W)) u_track (
    .clk      (clk),
    .rst_q    (rst_q),
    .msg_vld  (msg_vld),
    .msg_data (msg_data),
    .cand_nxt (cand_nxt),
    .cnt_nxt  (cnt_nxt)
  );

  eoc_accept_reg #(.MSG_W(MSG_W)) u_accept (
    .clk          (clk),
    .rst_q        (rst_q),
    .mode         (mode_e),
    .half_sf_tick (half_sf_tick),
    .msg_vld      (msg_vld),
    .cand_nxt     (cand_nxt),
    .cnt_nxt      (cnt_nxt),
    .irq_ack      (irq_ack),
    .rx_msg       (rx_msg),
    .irq          (irq),
    .held_vld     (held_vld)
  );

endmodule

// File: rtl/eoc_filter_chk.sv
module eoc_filter_chk #(
  parameter int MSG_W = 8
) (
  input logic             clk,
  input logic             rst_q,
  input logic             msg_vld,
  input logic [MSG_W-1:0] msg_data,
  input logic             half_sf_tick,
  input logic [1:0]       mode,
  input logic             irq_ack,
  input logic [MSG_W-1:0] rx_msg,
  input logic             irq,
  input logic             held_vld
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (irq && !irq_ack) |=> irq);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_ack && !msg_vld && !half_sf_tick) |=> !irq);

  p_tick_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd0 && half_sf_tick) |=> irq);

  p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd0 && !half_sf_tick) |=> ($stable(rx_msg) && !$rose(irq)));

  p_tick_ignored_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (mode != 2'd0 && !msg_vld) |=> ($stable(rx_msg) && !$rose(irq)));

  p_repeat_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (mode != 2'd0 && msg_vld && held_vld && msg_data == rx_msg)
      |=> ($stable(rx_msg) && !$rose(irq)));

  p_change_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd1 && msg_vld && (!held_vld || msg_data != rx_msg))
      |=> (irq && rx_msg == $past(msg_data)));

endmodule

bind eoc_validate_filter eoc_filter_chk #(.MSG_W(MSG_W)) u_chk (
  .clk          (clk),
  .rst_q        (rst_q),
  .msg_vld      (msg_vld),
  .msg_data     (msg_data),
  .half_sf_tick (half_sf_tick),
  .mode         (mode),
  .irq_ack      (irq_ack),
  .rx_msg       (rx_msg),
  .irq          (irq),
  .held_vld     (held_vld)
);

// File: tb/test_eoc_validate_filter.sv
`timescale 1ns/1ps
module test_eoc_validate_filter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msg_vld = 1'b0;
  logic [7:0] msg_data = '0;
  logic       half_sf_tick = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       irq_ack = 1'b0;
  logic [7:0] rx_msg;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_cand, m_rx;
  int         m_cnt;
  bit         m_held, m_irq;

  always #10 clk = ~clk;

  eoc_validate_filter i_eoc_validate_filter (
    .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg_data(msg_data),
    .half_sf_tick(half_sf_tick), .mode(mode), .irq_ack(irq_ack),
    .rx_msg(rx_msg), .irq(irq)
  );

  task automatic model_reset();
    m_cand = '0; m_rx = '0; m_cnt = 0; m_held = 0; m_irq = 0;
  endtask

  task automatic model_step(bit v, logic [7:0] d, bit t, bit a);
    bit ld;
    if (v) begin
      if (m_cnt != 0 && d == m_cand) begin
        if (m_cnt < 3) m_cnt++;
      end else begin
        m_cand = d; m_cnt = 1;
      end
    end
    if (mode == 2'd0) ld = t;
    else ld = v && (m_cnt >= int'(mode)) && (!m_held || m_cand != m_rx);
    if (ld) begin m_rx = m_cand; m_held = 1; m_irq = 1; end
    else if (a) m_irq = 0;
  endtask

  task automatic cyc(bit v, logic [7:0] d, bit t, bit a);
    @(negedge clk);
    msg_vld = v; msg_data = d; half_sf_tick = t; irq_ack = a;
    model_step(v, d, t, a);
    @(posedge clk);
    #2;
    msg_vld = 0; half_sf_tick = 0; irq_ack = 0;
  endtask

  task automatic chk(string tag, logic [7:0] exp_rx, logic exp_irq);
    checks++;
    if (rx_msg !== exp_rx || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: rx_msg=%0h irq=%0b expected rx_msg=%0h irq=%0b",
               tag, rx_msg, irq, exp_rx, exp_irq);
    end
  endtask

  initial begin
    int unused_seed;
    string tag;
    unused_seed = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(posedge clk);
    #2 chk("R1 during reset", 8'h00, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 chk("R1 after release", 8'h00, 1'b0);

    // mode 1: change-driven
    mode = 2'd1;
    cyc(1, 8'h00, 0, 0); chk("R11 first zero word", 8'h00, 1'b1);
    cyc(0, 8'h00, 0, 1); chk("R9 ack clears", 8'h00, 1'b0);
    cyc(1, 8'h00, 0, 0); chk("R5 repeat of held", 8'h00, 1'b0);
    cyc(1, 8'h05, 0, 0); chk("R4 new word", 8'h05, 1'b1);
    cyc(0, 8'h00, 0, 0); chk("R9 flag holds", 8'h05, 1'b1);
    cyc(1, 8'h09, 0, 1); chk("R9 load beats ack", 8'h09, 1'b1);
    cyc(0, 8'h00, 0, 1); chk("R9 ack clears", 8'h09, 1'b0);
    cyc(0, 8'h00, 1, 0); chk("R10 tick ignored", 8'h09, 1'b0);

    // mode 2: two in a row
    mode = 2'd2;
    cyc(1, 8'h07, 0, 0); chk("R6 first receipt", 8'h09, 1'b0);
    cyc(1, 8'h03, 0, 0); chk("R8 restart", 8'h09, 1'b0);
    cyc(1, 8'h03, 0, 0); chk("R6 second receipt", 8'h03, 1'b1);
    cyc(0, 8'h00, 0, 1);
    cyc(1, 8'h03, 0, 0); chk("R5 repeat in mode 2", 8'h03, 1'b0);

    // mode 3: three in a row
    mode = 2'd3;
    cyc(1, 8'h06, 0, 0);
    cyc(1, 8'h06, 0, 0); chk("R7 second receipt", 8'h03, 1'b0);
    cyc(1, 8'h06, 0, 0); chk("R7 third receipt", 8'h06, 1'b1);
    cyc(0, 8'h00, 0, 1);
    cyc(1, 8'h08, 0, 0);
    cyc(1, 8'h08, 0, 0);
    cyc(1, 8'h01, 0, 0);
    cyc(1, 8'h08, 0, 0);
    cyc(1, 8'h08, 0, 0); chk("R8 run broken", 8'h06, 1'b0);
    cyc(1, 8'h08, 0, 0); chk("R7 after restart", 8'h08, 1'b1);
    cyc(0, 8'h00, 1, 1); chk("R10 tick in mode 3", 8'h08, 1'b0);

    // mode 0: periodic pass-through
    mode = 2'd0;
    cyc(1, 8'h04, 0, 0); chk("R3 word without tick", 8'h08, 1'b0);
    cyc(0, 8'h00, 1, 0); chk("R2 tick loads latest", 8'h04, 1'b1);
    cyc(0, 8'h00, 0, 1);
    cyc(0, 8'h00, 1, 0); chk("R2 tick same content", 8'h04, 1'b1);
    cyc(1, 8'h02, 1, 1); chk("R2 tick with word", 8'h02, 1'b1);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 150 == 0) mode = 2'($urandom % 4);
      cyc(($urandom % 2) == 0, 8'($urandom % 4), ($urandom % 8) == 0,
          ($urandom % 4) == 0);
      case (mode)
        2'd0: tag = "R2 random";
        2'd1: tag = "R4 random";
        2'd2: tag = "R6 random";
        default: tag = "R7 random";
      endcase
      chk(tag, m_rx, m_irq);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule